// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register File

This block holds the software-visible registers of a two-channel disk bus-master DMA engine. They sit behind a 16-byte I/O window, and each channel owns an 8-byte slice of it. In each slice, a command byte and a status byte share a 4-byte byte-access region. A 32-bit descriptor-table pointer follows it. The I/O port carries one access per cycle, with a size code and an address. Read data comes back one cycle after the request.

The status byte mixes three kinds of bit. Some are plain read/write, some are cleared by writing one, and one is a read-only active flag that only the command register moves. Hardware pulses set each channel's interrupt and error flags. When a hardware set and a software clear land in the same cycle, the set wins. Each channel's interrupt level goes straight to its legacy interrupt line (line 14+n for channel n). A registered copy of that level appears as a configuration status flag.

Top module: `busmaster_regfile`

## Requirements
- R1: Bit 3 of `ioAddr` selects the channel. Within a slice, address bit 2 picks the pointer register (set) or the command/status region (clear). Accesses to one channel never change the other channel's registers, and `startPulse` bit n belongs to channel n.
- R2: In the command/status region, a byte read returns the command at local offset 0 and the status at local offset 2. Local offsets 1 and 3 return 0xFF. Byte data uses `ioWdata[7:0]` and `rdData[7:0]`, and the upper read bits are zero.
- R3: `ioSize` encodes the access size: 0 is one byte, 1 is two bytes, and 2 or 3 is four bytes. In the command/status region, a read of any size other than one byte returns all ones of that size (0xFFFF or 0xFFFFFFFF). A write of any size other than one byte changes nothing.
- R4: The command register keeps only bit 0 (start) and bit 3 (direction). Its other bits read as zero. Byte writes to local offsets 1 and 3 are dropped.
- R5: A command write that takes bit 0 from 0 to 1 sets status bit 0. In the cycle after the write, it also raises that channel's `startPulse` for exactly one cycle. Rewriting bit 0 as 1 when it is already 1 gives no pulse.
- R6: A command write with bit 0 equal to 0 clears status bit 0.
- R7: A byte write to status loads bits 5 and 6 from the data. It leaves bit 0 unchanged and clears bit 1 or bit 2 only where the data has a one. Status bits 3, 4 and 7 always read zero.
- R8: `hwIntSet[n]` sets status bit 2 and `hwErrSet[n]` sets status bit 1. A hardware set wins over a software clear of the same bit in the same cycle.
- R9: A 4-byte write to the pointer stores the data with bits 1:0 forced to zero, and a 4-byte read returns the stored value. Pointer accesses of other sizes read all ones of their size and do not write.
- R10: `cfgIrqFlag[n]` equals `irqIn[n]` delayed by one clock.
- R11: `legacyIrq[n]` follows `irqIn[n]` combinationally, with no clock delay.
- R12: Reset clears every command, status and pointer register, `cfgIrqFlag` and `startPulse`.
- R13: `rdValid` is high exactly in the cycle after a read request, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioValid | input | 1 | Access request this cycle |
| ioWrite | input | 1 | 1 = write, 0 = read |
| ioAddr | input | 4 | Byte address in the window |
| ioSize | input | 2 | Access size code |
| ioWdata | input | 32 | Write data |
| rdValid | output | 1 | Read data valid |
| rdData | output | 32 | Read data |
| hwIntSet | input | 2 | Per-channel interrupt flag set pulse |
| hwErrSet | input | 2 | Per-channel error flag set pulse |
| irqIn | input | 2 | Per-channel interrupt level |
| startPulse | output | 2 | Per-channel one-cycle start strobe |
| cfgIrqFlag | output | 2 | Registered per-channel interrupt mirror flag |
| legacyIrq | output | 2 | Legacy interrupt lines 14 and 15 |

## Verification
A wrong bit in a stored register shows up only when software reads it back. The bench therefore reads command, status and pointer after every mutation, and a bad value appears on `rdData` one cycle after that read request. Faults in the start-edge logic appear at `startPulse` in the cycle right after the command write. A broken interrupt mirror shows up on `cfgIrqFlag` one clock after `irqIn` changes. A fault in the legacy path shows up on `legacyIrq` in the same cycle.

// File: rtl/bm_regs_pkg.sv
package bm_regs_pkg;
  localparam int SLICE_BYTES  = 8;
  localparam int CMD_START    = 0;
  localparam int CMD_DIR      = 3;
  localparam logic [7:0] CMD_MASK = 8'h09;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } ioSize_e;

  // strobes from the decoder to one channel datapath
  typedef struct packed {
    logic        cmdWr;
    logic        statWr;
    logic        ptrWr;
    logic [7:0]  byteData;
    logic [31:0] wordData;
  } chanStrobe_t;

  function automatic logic [31:0] sizeOnes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: sizeOnes = 32'h0000_00FF;
      SZ_HALF: sizeOnes = 32'h0000_FFFF;
      default: sizeOnes = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/bm_regs_ctrl.sv
module bm_regs_ctrl
  import bm_regs_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = $clog2(NUM_CH) + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioValid,
  input  logic              ioWrite,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [1:0]        ioSize,
  input  logic [31:0]       ioWdata,
  input  logic [7:0]        chCmd  [NUM_CH],
  input  logic [7:0]        chStat [NUM_CH],
  input  logic [31:0]       chPtr  [NUM_CH],
  output chanStrobe_t       strb   [NUM_CH],
  output logic              rdValid,
  output logic [31:0]       rdData
);
  localparam int CH_W = ADDR_W - 3;

  logic [CH_W-1:0] chIdx;
  logic            ptrRegion;
  logic [1:0]      localOff;
  logic            isByte;
  logic            isWord;
  logic            chOk;
  logic [31:0]     rdNext;

  assign chIdx     = ioAddr[ADDR_W-1:3];
  assign ptrRegion = ioAddr[2];
  assign localOff  = ioAddr[1:0];
  assign isByte    = (ioSize == SZ_BYTE);
  assign isWord    = (ioSize == SZ_WORD) || (ioSize == SZ_WRD2);
  assign chOk      = (int'(chIdx) < NUM_CH);

  // write strobes, one set per channel
  for (genvar c = 0; c < NUM_CH; c++) begin : g_strb
    logic hit;
    assign hit = ioValid && ioWrite && chOk && (int'(chIdx) == c);
    always_comb begin
      strb[c].byteData = ioWdata[7:0];
      strb[c].wordData = ioWdata;
      strb[c].cmdWr    = hit && !ptrRegion && isByte && (localOff == 2'd0);
      strb[c].statWr   = hit && !ptrRegion && isByte && (localOff == 2'd2);
      strb[c].ptrWr    = hit &&  ptrRegion && isWord;
    end
  end

  // read mux
  always_comb begin
    rdNext = sizeOnes(ioSize);
    if (chOk) begin
      if (!ptrRegion) begin
        if (isByte) begin
          case (localOff)
            2'd0:    rdNext = {24'h0, chCmd[chIdx]};
            2'd2:    rdNext = {24'h0, chStat[chIdx]};
            default: rdNext = 32'h0000_00FF;
          endcase
        end
      end else if (isWord) begin
        rdNext = chPtr[chIdx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= ioValid && !ioWrite;
      if (ioValid && !ioWrite) rdData <= rdNext;
    end
  end

  // R13: read data valid only right after a read request
  assert_rd_follows_req_R13: assert property (@(posedge clk) disable iff (!rstN)
    (ioValid && !ioWrite) |=> rdValid);
  assert_rd_no_spurious_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(ioValid && !ioWrite) |=> !rdValid);
  // R3: a byte read in the command/status region never exceeds one byte
  assert_byte_read_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ioValid && !ioWrite && isByte && !ptrRegion) |=> (rdData[31:8] == 24'h0));
endmodule

// File: rtl/bm_chan_dp.sv
module bm_chan_dp
  import bm_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  chanStrobe_t strb,
  input  logic        hwIntSet,
  input  logic        hwErrSet,
  input  logic        irqIn,
  output logic [7:0]  cmdQ,
  output logic [7:0]  statQ,
  output logic [31:0] ptrQ,
  output logic        startPulse,
  output logic        cfgFlag
);
  logic [7:0] statNext;
  logic       startEdge;

  assign startEdge = strb.cmdWr && strb.byteData[CMD_START] && !cmdQ[CMD_START];

  always_comb begin
    statNext = statQ;
    if (strb.statWr) begin
      statNext[6:5] = strb.byteData[6:5];
      statNext[2:1] = statQ[2:1] & ~strb.byteData[2:1];
    end
    if (strb.cmdWr) begin
      if (startEdge)                         statNext[0] = 1'b1;
      else if (!strb.byteData[CMD_START])    statNext[0] = 1'b0;
    end
    if (hwIntSet) statNext[2] = 1'b1;
    if (hwErrSet) statNext[1] = 1'b1;
    statNext[7]   = 1'b0;
    statNext[4:3] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ       <= '0;
      statQ      <= '0;
      ptrQ       <= '0;
      startPulse <= 1'b0;
      cfgFlag    <= 1'b0;
    end else begin
      statQ      <= statNext;
      startPulse <= startEdge;
      cfgFlag    <= irqIn;
      if (strb.cmdWr) cmdQ <= strb.byteData & CMD_MASK;
      if (strb.ptrWr) ptrQ <= {strb.wordData[31:2], 2'b00};
    end
  end

  // R5: a start strobe always comes with the active bit set
  assert_start_sets_active_R5: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> statQ[0]);
  // R6: a stop write clears the active bit
  assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmdWr && !strb.byteData[CMD_START]) |=> !statQ[0]);
  // R8: hardware set wins
  assert_int_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    hwIntSet |=> statQ[2]);
  assert_err_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    hwErrSet |=> statQ[1]);
  // R7: status writes leave the active bit alone
  assert_active_ro_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statWr && !strb.cmdWr) |=> (statQ[0] == $past(statQ[0])));
  // R10: mirror flag tracks the level one clock later
  assert_cfg_mirror_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqIn |=> cfgFlag);
endmodule

// File: rtl/busmaster_regfile.sv
module busmaster_regfile
  import bm_regs_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = $clog2(NUM_CH) + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioValid,
  input  logic              ioWrite,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [1:0]        ioSize,
  input  logic [31:0]       ioWdata,
  output logic              rdValid,
  output logic [31:0]       rdData,
  input  logic [NUM_CH-1:0] hwIntSet,
  input  logic [NUM_CH-1:0] hwErrSet,
  input  logic [NUM_CH-1:0] irqIn,
  output logic [NUM_CH-1:0] startPulse,
  output logic [NUM_CH-1:0] cfgIrqFlag,
  output logic [NUM_CH-1:0] legacyIrq
);
  logic [7:0]  chCmd  [NUM_CH];
  logic [7:0]  chStat [NUM_CH];
  logic [31:0] chPtr  [NUM_CH];
  chanStrobe_t strb   [NUM_CH];

  bm_regs_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ioValid (ioValid),
    .ioWrite (ioWrite),
    .ioAddr  (ioAddr),
    .ioSize  (ioSize),
    .ioWdata (ioWdata),
    .chCmd   (chCmd),
    .chStat  (chStat),
    .chPtr   (chPtr),
    .strb    (strb),
    .rdValid (rdValid),
    .rdData  (rdData)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bm_chan_dp u_dp (
      .clk        (clk),
      .rstN       (rstN),
      .strb       (strb[c]),
      .hwIntSet   (hwIntSet[c]),
      .hwErrSet   (hwErrSet[c]),
      .irqIn      (irqIn[c]),
      .cmdQ       (chCmd[c]),
      .statQ      (chStat[c]),
      .ptrQ       (chPtr[c]),
      .startPulse (startPulse[c]),
      .cfgFlag    (cfgIrqFlag[c])
    );
  end

  // legacy lines are a pure pass-through of the channel level
  assign legacyIrq = irqIn;

  // R1: at most one channel starts per cycle (one access per cycle)
  assert_one_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(startPulse));
endmodule

// File: tb/sim_busmaster_regfile.sv
module sim_busmaster_regfile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioValid = 1'b0;
  logic        ioWrite = 1'b0;
  logic [3:0]  ioAddr = '0;
  logic [1:0]  ioSize = '0;
  logic [31:0] ioWdata = '0;
  logic        rdValid;
  logic [31:0] rdData;
  logic [1:0]  hwIntSet = '0;
  logic [1:0]  hwErrSet = '0;
  logic [1:0]  irqIn = '0;
  logic [1:0]  startPulse;
  logic [1:0]  cfgIrqFlag;
  logic [1:0]  legacyIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  busmaster_regfile u0 (
    .clk(clk), .rstN(rstN), .ioValid(ioValid), .ioWrite(ioWrite),
    .ioAddr(ioAddr), .ioSize(ioSize), .ioWdata(ioWdata),
    .rdValid(rdValid), .rdData(rdData), .hwIntSet(hwIntSet),
    .hwErrSet(hwErrSet), .irqIn(irqIn), .startPulse(startPulse),
    .cfgIrqFlag(cfgIrqFlag), .legacyIrq(legacyIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R13 actual=unexpected rdValid expected=none");
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, rdData, e);
      end
    end
  end

  task automatic doWrite(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d,
                         input logic [1:0] errSet = 2'b00);
    @(negedge clk);
    ioValid = 1; ioWrite = 1; ioAddr = a; ioSize = sz; ioWdata = d; hwErrSet = errSet;
    @(negedge clk);
    ioValid = 0; ioWrite = 0; hwErrSet = 0;
  endtask

  task automatic doRead(input logic [3:0] a, input logic [1:0] sz,
                        input logic [31:0] e, input string tag);
    @(negedge clk);
    expQ.push_back(e); tagQ.push_back(tag);
    ioValid = 1; ioWrite = 0; ioAddr = a; ioSize = sz;
    @(negedge clk);
    ioValid = 0;
  endtask

  task automatic pulseHw(input logic [1:0] i, input logic [1:0] e);
    @(negedge clk);
    hwIntSet = i; hwErrSet = e;
    @(negedge clk);
    hwIntSet = 0; hwErrSet = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R12 reset state
    check("R12 cfgIrqFlag", {30'h0, cfgIrqFlag}, 0);
    check("R12 startPulse", {30'h0, startPulse}, 0);
    check("R13 rdValid idle", {31'h0, rdValid}, 0);
    doRead(4'h0, 2'd0, 32'h0, "R12 cmd0");
    doRead(4'h2, 2'd0, 32'h0, "R12 stat0");
    doRead(4'h4, 2'd2, 32'h0, "R12 ptr0");
    doRead(4'hC, 2'd2, 32'h0, "R12 ptr1");

    // R5 start
    doWrite(4'h0, 2'd0, 32'h09);
    check("R5 startPulse", {30'h0, startPulse}, 32'h1);
    @(negedge clk);
    check("R5 pulse one cycle", {30'h0, startPulse}, 32'h0);
    doRead(4'h0, 2'd0, 32'h09, "R4 cmd readback");
    doRead(4'h2, 2'd0, 32'h01, "R5 active set");
    doWrite(4'h0, 2'd0, 32'hFF);
    check("R5 no repulse", {30'h0, startPulse}, 32'h0);
    doRead(4'h0, 2'd0, 32'h09, "R4 cmd mask");

    // R7 status write rules
    doWrite(4'h2, 2'd0, 32'hFF);
    doRead(4'h2, 2'd0, 32'h61, "R7 stat 0xFF");
    doWrite(4'h2, 2'd0, 32'h00);
    doRead(4'h2, 2'd0, 32'h01, "R7 stat 0x00");

    // R8 hardware sets
    pulseHw(2'b01, 2'b00);
    doRead(4'h2, 2'd0, 32'h05, "R8 int set");
    pulseHw(2'b00, 2'b01);
    doRead(4'h2, 2'd0, 32'h07, "R8 err set");
    doWrite(4'h2, 2'd0, 32'h04);
    doRead(4'h2, 2'd0, 32'h03, "R7 w1c bit2");
    doWrite(4'h2, 2'd0, 32'h02, 2'b01);
    doRead(4'h2, 2'd0, 32'h03, "R8 set beats clear");

    // R2 / R4 reserved offsets
    doRead(4'h1, 2'd0, 32'hFF, "R2 off1");
    doRead(4'h3, 2'd0, 32'hFF, "R2 off3");
    doWrite(4'h1, 2'd0, 32'h00);
    doWrite(4'h3, 2'd0, 32'h00);
    doRead(4'h0, 2'd0, 32'h09, "R4 off1/3 dropped");
    doRead(4'h2, 2'd0, 32'h03, "R4 off3 no stat change");

    // R3 size checks
    doRead(4'h0, 2'd1, 32'hFFFF, "R3 half read");
    doRead(4'h2, 2'd2, 32'hFFFF_FFFF, "R3 word read");
    doWrite(4'h0, 2'd1, 32'h0);
    doRead(4'h0, 2'd0, 32'h09, "R3 half write ignored");
    doWrite(4'h2, 2'd2, 32'hFF);
    doRead(4'h2, 2'd0, 32'h03, "R3 word write ignored");

    // R6 stop
    doWrite(4'h0, 2'd0, 32'h08);
    doRead(4'h2, 2'd0, 32'h02, "R6 stop clears active");
    doRead(4'h0, 2'd0, 32'h08, "R4 dir kept");

    // R9 pointer
    doWrite(4'h4, 2'd2, 32'h1234_5677);
    doRead(4'h4, 2'd2, 32'h1234_5674, "R9 ptr align");
    doWrite(4'h4, 2'd1, 32'hFFFF);
    doRead(4'h4, 2'd2, 32'h1234_5674, "R9 half write ignored");
    doRead(4'h4, 2'd1, 32'hFFFF, "R9 half read ones");

    // R1 channel separation
    doWrite(4'h8, 2'd0, 32'h01);
    check("R1 ch1 startPulse", {30'h0, startPulse}, 32'h2);
    doRead(4'h8, 2'd0, 32'h01, "R1 ch1 cmd");
    doRead(4'hA, 2'd0, 32'h01, "R1 ch1 stat");
    doRead(4'h0, 2'd0, 32'h08, "R1 ch0 cmd untouched");
    doRead(4'hC, 2'd2, 32'h0, "R1 ch1 ptr untouched");

    // R10 / R11 interrupt paths
    @(negedge clk);
    irqIn = 2'b10;
    #1;
    check("R11 legacy same cycle", {30'h0, legacyIrq}, 32'h2);
    check("R10 cfg not yet", {30'h0, cfgIrqFlag}, 32'h0);
    @(negedge clk);
    check("R10 cfg set", {30'h0, cfgIrqFlag}, 32'h2);
    irqIn = 2'b01;
    #1;
    check("R11 legacy ch0", {30'h0, legacyIrq}, 32'h1);
    @(negedge clk);
    check("R10 cfg follows", {30'h0, cfgIrqFlag}, 32'h1);
    irqIn = 2'b00;
    @(negedge clk);
    check("R10 cfg cleared", {30'h0, cfgIrqFlag}, 32'h0);

    // R12 reset mid-run
    irqIn = 2'b11;
    @(negedge clk);
    rstN = 0;
    repeat (2) @(negedge clk);
    irqIn = 2'b00;
    check("R12 cfg in reset", {30'h0, cfgIrqFlag}, 32'h0);
    rstN = 1;
    doRead(4'h0, 2'd0, 32'h0, "R12 cmd0 after reset");
    doRead(4'h2, 2'd0, 32'h0, "R12 stat0 after reset");
    doRead(4'h4, 2'd2, 32'h0, "R12 ptr0 after reset");
    doRead(4'h8, 2'd0, 32'h0, "R12 cmd1 after reset");

    repeat (3) @(negedge clk);
    check("R13 queue drained", expQ.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule